// File: doc/BRIEF.md
# Peripheral Request Router and Channel Arbiter

This block sits between a set of peripheral request lines and a bank of DMA channels. Software programs one routing register per request line. Each register holds an enable bit and the number of the channel that the line drives. The router combines every enabled line aimed at a channel. That channel then counts as pending, but only while it reports that it is running and that flow control is on.

An arbiter picks one pending channel at a time for the shared bus. Channels fall into four fixed priority tiers, taken from bits 3:2 of the channel index, so the pattern repeats every sixteen channels. Channels in the same tier take turns in round-robin order. A grant stays with its channel until the bus side signals that the burst is finished.

The block also presents a read-only summary word with one bit per channel. Each bit follows that channel's own interrupt flag. The data movement itself is handled elsewhere.

Top module: `req_router_arb`

## Requirements
- R1: The routing register of line n is at byte address 0x100 + 4n for n below 64, and at 0x1100 + 4(n-64) for n of 64 and above. Bit 7 is the enable bit and bits 4:0 are the target channel. The register reads back exactly those fields, and every other bit reads as 0.
- R2: A request on a line whose enable bit is 0 never makes any channel pending and never produces a grant.
- R3: A channel is pending when at least one enabled line routed to it is requesting, it is running, and its flow control is on. The pending state is registered. A grant for a request presented before clock edge E is first visible after edge E+1, provided the arbiter is idle.
- R4: A channel's tier is its index bits 3:2, and tier 0 ranks highest. When the arbiter is idle it grants a channel from the highest-ranked tier that has any pending channel.
- R5: Within a tier, the channel granted is the first pending channel of that tier found by searching upward from the tier's previously granted channel, wrapping at the top. After reset the search starts at channel 0.
- R6: While a grant is active and burst-done is low, the grant valid and the granted channel number stay unchanged, even if higher-ranked requests arrive. At the edge where burst-done is high the grant drops, and it stays low for at least one cycle.
- R7: Reading address 0xF0 returns the live per-channel interrupt flags, bit c for channel c. Writes to 0xF0 are ignored, and a bit reads 0 as soon as that channel's flag clears.
- R8: Addresses that hold no routing register and are not 0xF0 read as 0. Writes to them change no register.
- R9: After reset every routing register reads 0 and no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte address |
| regWr | input | 1 | Register write strobe |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational from regAddr) |
| perReq | input | NUM_LINES | Peripheral request lines |
| chRun | input | NUM_CH | Channel is running |
| chFlow | input | NUM_CH | Channel has flow control enabled |
| chIrq | input | NUM_CH | Per-channel interrupt flag |
| burstDone | input | 1 | The granted channel has finished its burst |
| grantValid | output | 1 | A grant is active |
| grantCh | output | 5 | Number of the granted channel |

## Verification
The bound checker watches four things on every clock. It checks that a held grant stays put until burst-done and then drops. It checks that an idle arbiter with a pending channel grants on the next edge. It checks that each new grant goes to a channel that was pending, with no pending channel in a higher-ranked tier. It checks that the summary address always shows the live interrupt flags.

Other behaviours only show up through the bench's scenarios, compared against its behavioural model. These are:
- the routing register layout, including the upper bank;
- an unrouted or gated request being ignored;
- the two-edge request-to-grant latency;
- the exact round-robin order within a tier;
- writes that must leave the registers unchanged.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int MAX_CH   = 32;
  localparam int CH_IDX_W = 5;
  localparam int LEVELS   = 4;
  localparam int MAP_VALID_BIT = 7;
  localparam int SUM_OFFSET = 'h0F0;

  typedef struct packed {
    logic                load;
    logic                drop;
    logic [CH_IDX_W-1:0] pick;
  } arbStrobe_t;

  // byte address of the routing register for request line n
  function automatic int mapAddr(int n);
    if (n < 64) return 'h100 + 4 * n;
    return 'h1100 + 4 * (n - 64);
  endfunction
endpackage

// File: rtl/router_dp.sv
module router_dp
  import router_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_LINES = 72,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic                              regWr,
  input  logic [DATA_W-1:0]                 regWdata,
  output logic [DATA_W-1:0]                 regRdata,
  input  logic [NUM_LINES-1:0]              perReq,
  input  logic [NUM_CH-1:0]                 chRun,
  input  logic [NUM_CH-1:0]                 chFlow,
  input  logic [NUM_CH-1:0]                 chIrq,
  input  arbStrobe_t                        st,
  output logic [NUM_CH-1:0]                 pendVec,
  output logic                              grantValid,
  output logic [CH_IDX_W-1:0]               grantCh,
  output logic [LEVELS-1:0][CH_IDX_W-1:0]   lastPtr
);
  logic [NUM_LINES-1:0] mapValid;
  logic [CH_IDX_W-1:0]  mapCh [NUM_LINES];

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic                vQ;
    logic [CH_IDX_W-1:0] cQ;
    logic                hit;
    assign hit = regWr && (int'(regAddr) == mapAddr(n));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        cQ <= '0;
      end else if (hit) begin
        vQ <= regWdata[MAP_VALID_BIT];
        cQ <= regWdata[CH_IDX_W-1:0];
      end
    end
    assign mapValid[n] = vQ;
    assign mapCh[n]    = cQ;
  end

  // route enabled requesting lines onto channels
  logic [MAX_CH-1:0] hitAll;
  always_comb begin
    hitAll = '0;
    for (int n = 0; n < NUM_LINES; n++)
      if (mapValid[n] && perReq[n]) hitAll[mapCh[n]] = 1'b1;
  end

  logic [NUM_CH-1:0] pendQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= hitAll[NUM_CH-1:0] & chRun & chFlow;
  end
  assign pendVec = pendQ;

  // grant state and per-tier rotation pointers
  logic                            gvQ;
  logic [CH_IDX_W-1:0]             gcQ;
  logic [LEVELS-1:0][CH_IDX_W-1:0] ptrQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gvQ <= 1'b0;
      gcQ <= '0;
      for (int l = 0; l < LEVELS; l++) ptrQ[l] <= CH_IDX_W'(NUM_CH - 1);
    end else if (st.load) begin
      gvQ <= 1'b1;
      gcQ <= st.pick;
      ptrQ[st.pick[3:2]] <= st.pick;
    end else if (st.drop) begin
      gvQ <= 1'b0;
    end
  end
  assign grantValid = gvQ;
  assign grantCh    = gcQ;
  assign lastPtr    = ptrQ;

  // register read mux
  always_comb begin
    regRdata = '0;
    if (int'(regAddr) == SUM_OFFSET) regRdata[NUM_CH-1:0] = chIrq;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (int'(regAddr) == mapAddr(n)) begin
        regRdata[MAP_VALID_BIT]  = mapValid[n];
        regRdata[CH_IDX_W-1:0]   = mapCh[n];
      end
    end
  end
endmodule

// File: rtl/router_ctrl.sv
module router_ctrl
  import router_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic [NUM_CH-1:0]               pendVec,
  input  logic                            grantValid,
  input  logic                            burstDone,
  input  logic [LEVELS-1:0][CH_IDX_W-1:0] lastPtr,
  output arbStrobe_t                      st
);
  logic found;
  int   cand;

  always_comb begin
    st    = '0;
    found = 1'b0;
    cand  = 0;
    if (grantValid) begin
      st.drop = burstDone;
    end else begin
      for (int lv = 0; lv < LEVELS; lv++) begin
        for (int k = 1; k <= NUM_CH; k++) begin
          cand = (int'(lastPtr[lv]) + k) % NUM_CH;
          if (!found && pendVec[cand] && (((cand >> 2) % LEVELS) == lv)) begin
            found   = 1'b1;
            st.load = 1'b1;
            st.pick = CH_IDX_W'(cand);
          end
        end
      end
    end
  end
endmodule

// File: rtl/req_router_arb.sv
module req_router_arb
  import router_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_LINES = 72,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic [NUM_LINES-1:0] perReq,
  input  logic [NUM_CH-1:0]    chRun,
  input  logic [NUM_CH-1:0]    chFlow,
  input  logic [NUM_CH-1:0]    chIrq,
  input  logic                 burstDone,
  output logic                 grantValid,
  output logic [4:0]           grantCh
);
  arbStrobe_t                      st;
  logic [NUM_CH-1:0]               pendVec;
  logic [LEVELS-1:0][CH_IDX_W-1:0] lastPtr;

  router_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .pendVec(pendVec), .grantValid(grantValid), .burstDone(burstDone),
    .lastPtr(lastPtr), .st(st)
  );

  router_dp #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .perReq(perReq), .chRun(chRun), .chFlow(chFlow), .chIrq(chIrq),
    .st(st), .pendVec(pendVec), .grantValid(grantValid), .grantCh(grantCh), .lastPtr(lastPtr)
  );
endmodule

// File: rtl/router_checker.sv
module router_checker #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              grantValid,
  input logic [4:0]        grantCh,
  input logic              burstDone,
  input logic [NUM_CH-1:0] pendVec,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic [NUM_CH-1:0] chIrq
);
  logic [NUM_CH-1:0] pendPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendPrev <= '0;
    else       pendPrev <= pendVec;
  end

  logic betterSeen;
  always_comb begin
    betterSeen = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (pendPrev[c] && (((c >> 2) % 4) < int'(grantCh[3:2]))) betterSeen = 1'b1;
  end

  a_r6_grant_hold: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !burstDone |=> grantValid && $stable(grantCh));

  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && burstDone |=> !grantValid);

  a_r3_progress: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid && (|pendVec) |=> grantValid);

  a_r4_tier_order: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> pendPrev[grantCh] && !betterSeen);

  a_r7_summary: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) == 'h0F0) |-> regRdata == DATA_W'(chIrq));
endmodule

bind req_router_arb router_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantCh(grantCh), .burstDone(burstDone),
  .pendVec(pendVec), .regAddr(regAddr), .regRdata(regRdata), .chIrq(chIrq)
);

// File: tb/sim_req_router_arb.sv
`timescale 1ns/1ps
module sim_req_router_arb;
  localparam int NCH = 32;
  localparam int NL  = 72;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [15:0]     regAddr = '0;
  logic            regWr = 1'b0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [NL-1:0]   perReq = '0;
  logic [NCH-1:0]  chRun = '1;
  logic [NCH-1:0]  chFlow = '1;
  logic [NCH-1:0]  chIrq = '0;
  logic            burstDone = 1'b0;
  logic            grantValid;
  logic [4:0]      grantCh;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  req_router_arb #(.NUM_CH(NCH), .NUM_LINES(NL)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .perReq(perReq), .chRun(chRun), .chFlow(chFlow), .chIrq(chIrq),
    .burstDone(burstDone), .grantValid(grantValid), .grantCh(grantCh)
  );

  // behavioural reference model
  bit       mValid [NL];
  int       mCh    [NL];
  bit [NCH-1:0] mPend;
  bit       mGv;
  int       mGc;
  int       mLast [4];

  function automatic int lineOf(int a);
    if (a >= 'h100 && a < 'h200 && (a % 4) == 0) return (a - 'h100) / 4;
    if (a >= 'h1100 && a < 'h1200 && (a % 4) == 0) return 64 + (a - 'h1100) / 4;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mGv = 0; mGc = 0; mPend = '0;
      for (int l = 0; l < NL; l++) begin mValid[l] = 0; mCh[l] = 0; end
      for (int t = 0; t < 4; t++) mLast[t] = NCH - 1;
    end else begin
      bit [NCH-1:0] nxt;
      if (mGv) begin
        if (burstDone) mGv = 0;
      end else if (mPend != 0) begin
        int best;
        best = -1;
        for (int t = 0; t < 4 && best < 0; t++) begin
          int bestDist;
          bestDist = NCH + 1;
          for (int c = 0; c < NCH; c++) begin
            if ((c / 4) % 4 == t && mPend[c]) begin
              int d;
              d = (c - mLast[t] - 1 + 2 * NCH) % NCH;
              if (d < bestDist) begin bestDist = d; best = c; end
            end
          end
        end
        mGv = 1; mGc = best; mLast[(best / 4) % 4] = best;
      end
      nxt = '0;
      for (int l = 0; l < NL; l++) if (mValid[l] && perReq[l]) nxt[mCh[l]] = 1'b1;
      mPend = nxt & chRun & chFlow;
      if (regWr) begin
        int n;
        n = lineOf(int'(regAddr));
        if (n >= 0 && n < NL) begin mValid[n] = regWdata[7]; mCh[n] = int'(regWdata[4:0]); end
      end
    end
  end

  // cycle-by-cycle comparison of the grant outputs
  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (grantValid !== mGv || (mGv && int'(grantCh) != mGc)) begin
        bad++;
        $display("FAIL R4 R5 R6 model compare: got gv=%0d ch=%0d exp gv=%0d ch=%0d",
                 grantValid, grantCh, mGv, mGc);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic release_grant();
    @(negedge clk); burstDone = 1'b1;
    @(negedge clk); burstDone = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int expSeq [4] = '{0, 1, 2, 0};
    tick(3);
    rstN = 1'b1;
    // R9 reset state
    rd(16'h0100, d); chk("R9 map after reset", d, 32'h0);
    rd(16'h1100, d); chk("R9 upper map after reset", d, 32'h0);
    chk("R9 no grant after reset", {31'b0, grantValid}, 32'h0);

    // R1 routing registers
    wr(16'h0100, 32'h85);          // line0 -> ch5
    wr(16'h0104, 32'hFFFF_FF90);   // line1 -> ch16
    wr(16'h0108, 32'h03);          // line2 disabled, ch3
    wr(16'h010C, 32'h84);          // line3 -> ch4
    wr(16'h0110, 32'h80);          // line4 -> ch0
    wr(16'h0114, 32'h81);          // line5 -> ch1
    wr(16'h0118, 32'h82);          // line6 -> ch2
    wr(16'h1100, 32'h9F);          // line64 -> ch31
    wr(16'h111C, 32'h8A);          // line71 -> ch10
    rd(16'h0100, d); chk("R1 line0 readback", d, 32'h85);
    rd(16'h0104, d); chk("R1 other bits read zero", d, 32'h90);
    rd(16'h0108, d); chk("R1 disabled line readback", d, 32'h03);
    rd(16'h1100, d); chk("R1 line64 upper bank", d, 32'h9F);
    rd(16'h111C, d); chk("R1 line71 upper bank", d, 32'h8A);

    // R8 unmapped addresses
    wr(16'h2000, 32'hFF);
    rd(16'h2000, d); chk("R8 unmapped read", d, 32'h0);
    rd(16'h1120, d); chk("R8 beyond last line", d, 32'h0);
    rd(16'h0102, d); chk("R8 misaligned", d, 32'h0);
    rd(16'h0100, d); chk("R8 neighbour unchanged", d, 32'h85);

    // R2 disabled line ignored
    @(negedge clk); perReq[2] = 1'b1;
    tick(4); chk("R2 disabled line no grant", {31'b0, grantValid}, 32'h0);
    perReq[2] = 1'b0;

    // R3 flow gating and latency
    chFlow[5] = 1'b0; perReq[0] = 1'b1;
    tick(4); chk("R3 flow off no grant", {31'b0, grantValid}, 32'h0);
    chFlow[5] = 1'b1;
    tick(1); chk("R3 not yet after one edge", {31'b0, grantValid}, 32'h0);
    tick(1); chk("R3 grant after two edges", {31'b0, grantValid}, 32'h1);
    chk("R3 granted channel", {27'b0, grantCh}, 32'd5);
    perReq[0] = 1'b0;
    release_grant();
    chk("R6 drop after burst done", {31'b0, grantValid}, 32'h0);
    tick(2);

    // R3 two lines onto one channel, one enabled line requesting
    wr(16'h0108, 32'h9F);          // line2 -> ch31 as well as line64
    @(negedge clk); perReq[64] = 1'b1;
    tick(2); chk("R3 shared channel grant", {27'b0, grantCh}, 32'd31);
    perReq[64] = 1'b0;
    release_grant(); tick(2);

    // R4 tier priority, R6 hold
    perReq[3] = 1'b1; perReq[1] = 1'b1;
    tick(2); chk("R4 tier0 beats tier1", {27'b0, grantCh}, 32'd16);
    perReq[4] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk("R6 grant held valid", {31'b0, grantValid}, 32'h1);
      chk("R6 grant held channel", {27'b0, grantCh}, 32'd16);
    end
    perReq[4] = 1'b0;
    release_grant();
    chk("R6 release", {31'b0, grantValid}, 32'h0);
    tick(1); chk("R4 tier0 again", {27'b0, grantCh}, 32'd16);
    perReq[1] = 1'b0;
    release_grant();
    tick(1); chk("R4 lower tier served", {27'b0, grantCh}, 32'd4);
    perReq[3] = 1'b0;
    release_grant(); tick(2);

    // R5 rotation in tier 0, previous grant was ch16
    perReq[4] = 1'b1; perReq[5] = 1'b1; perReq[6] = 1'b1;
    tick(2);
    for (int i = 0; i < 4; i++) begin
      chk("R5 rotation order", {27'b0, grantCh}, 32'(expSeq[i]));
      release_grant();
      tick(1);
    end
    perReq[6:4] = '0;
    release_grant(); tick(2);

    // R7 summary register
    chIrq = 32'hA000_0101;
    rd(16'h00F0, d); chk("R7 summary live", d, 32'hA000_0101);
    wr(16'h00F0, 32'hFFFF_FFFF);
    rd(16'h00F0, d); chk("R7 write ignored", d, 32'hA000_0101);
    chIrq[8] = 1'b0;
    rd(16'h00F0, d); chk("R7 bit clears with flag", d, 32'hA000_0001);

    tick(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule